// File: doc/BRIEF.md
# SPI Byte-Memory Target Front End

This block lets an SPI host reach a 16K x 8 byte memory. It runs on a fast system clock and sees the serial pins only through synchronizers. Its bit engine samples the serial input on rising serial-clock edges and moves the serial output on falling edges. Because of this, one datapath serves both the idle-low and the idle-high clock polarity without a mode switch. Each select window carries one command. The command is an 8-bit opcode, then a 2-byte address for memory accesses, then a stream of data bytes with the address advancing after each byte.

The block does not decide write permission. Enable-latch and status-register commands leave as single-cycle strobes to a neighbouring protection unit, and that unit also returns the current status byte. Every received memory write byte is offered to that unit together with its address, and the byte lands in the array only when the unit grants it in the same cycle. The block also has a pause input that freezes the transfer mid-byte, and a low-activity sleep state that only a wake opcode can leave.

Top module: `spi_mem_target`

## Requirements
- R1: Serial input is taken on rising serial-clock edges and the output moves on falling edges. Data written with the clock idling low reads back identically with the clock idling high, and the reverse also holds. The polarity is set by the clock level when select falls.
- R2: Opcode 06h pulses `wel_set_o` once at the select rise. Opcode 04h pulses `wel_clr_o` once. Neither opcode pulses the other strobe.
- R3: Opcode 05h streams `sr_rd_i` MSB first on `so_o` for every byte clocked after the opcode.
- R4: Opcode 01h followed by one complete byte pulses `sr_wr_o` at the select rise, with `sr_data_o` equal to that byte.
- R5: Opcode 03h, then a 16-bit address sent MSB first, returns array bytes MSB first from consecutive addresses.
- R6: Opcode 02h, then the address, pulses `wr_chk_o` once per complete data byte, with `wr_addr_o` and `wr_data_o`. The byte is stored only if `wr_grant_i` is high in that cycle. The array model holds 2^MEM_AW bytes indexed by the low address bits.
- R7: The two top address bits are ignored. The burst address counts up by one per byte and wraps from 3FFFh to 0000h.
- R8: If select rises with a partial byte, that byte is dropped. It produces no write pulse, no status pulse and no enable-latch pulse.
- R9: Only one command runs per select window. Bytes that follow a complete no-data opcode are ignored.
- R10: While `holdn_i` is low, `so_oe_o` is low and serial-clock and select transitions are ignored. The transfer resumes intact when `holdn_i` returns high.
- R11: While select is high, `so_oe_o` stays low and clock or data activity produces no strobe.
- R12: Opcode B9h sets `asleep_o` at the select rise. While asleep, every opcode except ABh is ignored. ABh clears `asleep_o` at its select rise.
- R13: `so_oe_o` is high only during the data phase of opcodes 03h and 05h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low select |
| si_i | input | 1 | Serial data from host |
| holdn_i | input | 1 | Active-low pause |
| so_o | output | 1 | Serial data to host |
| so_oe_o | output | 1 | Output enable for `so_o` |
| wel_set_o | output | 1 | Enable-latch set strobe |
| wel_clr_o | output | 1 | Enable-latch clear strobe |
| sr_wr_o | output | 1 | Status write request strobe |
| sr_data_o | output | 8 | Status byte offered with `sr_wr_o` |
| sr_rd_i | input | 8 | Current status byte |
| wr_chk_o | output | 1 | Memory write request strobe |
| wr_addr_o | output | ADDR_W | Address of the offered write byte |
| wr_data_o | output | 8 | Offered write byte |
| wr_grant_i | input | 1 | Permission for the offered byte |
| asleep_o | output | 1 | Sleep state flag |

## Verification
The hardest case to reach is a pause that lands in the middle of a byte. During that pause the clock toggles and select briefly rises, and the transfer must then finish as if nothing had happened. The bench stops a write and a read after a few bits, drops the pause line, toggles the clock and select, restores the clock level, releases the pause and completes the byte. It then checks the written value, the read value and the enable. A trailing partial byte is reached by ending the select window a few bits into a write or status byte, with known prior array contents, so that any commit shows up on readback.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_RD, PH_WR, PH_SRD, PH_SWR, PH_DONE
  } phase_e;

  localparam logic [7:0] OP_WEN = 8'h06;
  localparam logic [7:0] OP_WDI = 8'h04;
  localparam logic [7:0] OP_RSR = 8'h05;
  localparam logic [7:0] OP_WSR = 8'h01;
  localparam logic [7:0] OP_RD  = 8'h03;
  localparam logic [7:0] OP_WR  = 8'h02;
  localparam logic [7:0] OP_SLP = 8'hB9;
  localparam logic [7:0] OP_WAK = 8'hAB;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_byte_array.sv
module spi_byte_array #(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              si_s,
  input  logic              holdn_s,
  input  logic [7:0]        sr_rd_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              sr_wr_o,
  output logic [7:0]        sr_data_o,
  output logic              wr_chk_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wr_data_o,
  output logic              asleep_o
);
  phase_e            phase_q, phase_d;
  logic [2:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d, opc_q, opc_d, tx_q, tx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              abyte_q, abyte_d, got_q, got_d;
  logic              sck_q, csn_q, asleep_q, asleep_d;

  logic       cs_fall, cs_rise, rise, fall, sel;
  logic [7:0] nbyte;

  assign sel     = ~csn_q;
  assign cs_fall = holdn_s & csn_q & ~csn_s;
  assign cs_rise = holdn_s & ~csn_q & csn_s;
  assign rise    = holdn_s & sel & ~csn_s & sck_s & ~sck_q;
  assign fall    = holdn_s & sel & ~csn_s & ~sck_s & sck_q;
  assign nbyte   = {sh_q[6:0], si_s};

  always_comb begin
    phase_d   = phase_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    opc_d     = opc_q;
    tx_d      = tx_q;
    addr_d    = addr_q;
    abyte_d   = abyte_q;
    got_d     = got_q;
    asleep_d  = asleep_q;
    wel_set_o = 1'b0;
    wel_clr_o = 1'b0;
    sr_wr_o   = 1'b0;
    wr_chk_o  = 1'b0;
    if (cs_fall) begin
      phase_d = PH_OPC;
      bit_d   = 3'd0;
      abyte_d = 1'b0;
      got_d   = 1'b0;
    end else if (cs_rise) begin
      phase_d = PH_IDLE;
      if (bit_q == 3'd0 && phase_q != PH_OPC && phase_q != PH_IDLE) begin
        case (opc_q)
          OP_WEN:  wel_set_o = 1'b1;
          OP_WDI:  wel_clr_o = 1'b1;
          OP_WSR:  sr_wr_o   = got_q;
          OP_SLP:  asleep_d  = 1'b1;
          OP_WAK:  asleep_d  = 1'b0;
          default: ;
        endcase
      end
    end else if (rise) begin
      sh_d  = nbyte;
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        case (phase_q)
          PH_OPC: begin
            if (asleep_q && nbyte != OP_WAK) begin
              opc_d   = 8'h00;
              phase_d = PH_DONE;
            end else begin
              opc_d = nbyte;
              case (nbyte)
                OP_RD, OP_WR: phase_d = PH_ADDR;
                OP_RSR:       phase_d = PH_SRD;
                OP_WSR:       phase_d = PH_SWR;
                default:      phase_d = PH_DONE;
              endcase
            end
          end
          PH_ADDR: begin
            abyte_d = 1'b1;
            if (!abyte_q) addr_d = ADDR_W'({nbyte, 8'h00});
            else begin
              addr_d  = {addr_q[ADDR_W-1:8], nbyte};
              phase_d = (opc_q == OP_RD) ? PH_RD : PH_WR;
            end
          end
          PH_WR: begin
            wr_chk_o = 1'b1;
            addr_d   = addr_q + 1'b1;
          end
          PH_SWR: begin
            addr_d[7:0] = nbyte;
            got_d       = 1'b1;
            phase_d     = PH_DONE;
          end
          default: ;
        endcase
      end
    end else if (fall && (phase_q == PH_RD || phase_q == PH_SRD)) begin
      if (bit_q == 3'd0) begin
        tx_d = (phase_q == PH_RD) ? mem_rdata_i : sr_rd_i;
        if (phase_q == PH_RD) addr_d = addr_q + 1'b1;
      end else begin
        tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      opc_q    <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      abyte_q  <= 1'b0;
      got_q    <= 1'b0;
      asleep_q <= 1'b0;
      sck_q    <= 1'b0;
      csn_q    <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      opc_q    <= opc_d;
      tx_q     <= tx_d;
      addr_q   <= addr_d;
      abyte_q  <= abyte_d;
      got_q    <= got_d;
      asleep_q <= asleep_d;
      sck_q    <= sck_s;
      if (holdn_s) csn_q <= csn_s;
    end
  end

  assign so_o      = tx_q[7];
  assign so_oe_o   = holdn_s & sel & (phase_q == PH_RD || phase_q == PH_SRD);
  assign sr_data_o = addr_q[7:0];
  assign addr_o    = addr_q;
  assign wr_data_o = nbyte;
  assign asleep_o  = asleep_q;

  // R11
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && holdn_s) |=> !so_oe_o);

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !holdn_s |=> ($stable(phase_q) && $stable(bit_q) && $stable(addr_q)));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chk_o |=> (addr_q == $past(addr_q) + 1'b1));

  // R12
  sleep_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q |-> !(wel_set_o || wel_clr_o || sr_wr_o || wr_chk_o));

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wel_set_o, wel_clr_o, sr_wr_o, wr_chk_o}) <= 1);
endmodule

// File: rtl/spi_mem_target.sv
module spi_mem_target #(
  parameter int ADDR_W      = 14,
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              si_i,
  input  logic              holdn_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              sr_wr_o,
  output logic [7:0]        sr_data_o,
  input  logic [7:0]        sr_rd_i,
  output logic              wr_chk_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  input  logic              wr_grant_i,
  output logic              asleep_o
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pins_s;
  logic [7:0]      mem_rdata;
  logic            mem_we;

  spi_pin_sync #(
    .WIDTH   (NPIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1100)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({holdn_i, csn_i, sck_i, si_i}),
    .q_o   (pins_s)
  );

  spi_cmd_engine #(.ADDR_W(ADDR_W)) eng_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_s       (pins_s[1]),
    .csn_s       (pins_s[2]),
    .si_s        (pins_s[0]),
    .holdn_s     (pins_s[3]),
    .sr_rd_i     (sr_rd_i),
    .mem_rdata_i (mem_rdata),
    .so_o        (so_o),
    .so_oe_o     (so_oe_o),
    .wel_set_o   (wel_set_o),
    .wel_clr_o   (wel_clr_o),
    .sr_wr_o     (sr_wr_o),
    .sr_data_o   (sr_data_o),
    .wr_chk_o    (wr_chk_o),
    .addr_o      (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .asleep_o    (asleep_o)
  );

  assign mem_we = wr_chk_o & wr_grant_i;

  spi_byte_array #(.MEM_AW(MEM_AW)) mem_i (
    .clk     (clk),
    .we_i    (mem_we),
    .addr_i  (wr_addr_o[MEM_AW-1:0]),
    .wdata_i (wr_data_o),
    .rdata_o (mem_rdata)
  );
endmodule

// File: tb/spi_mem_target_tb.sv
module spi_mem_target_tb_top;
  localparam int H = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, si = 1'b0, holdn = 1'b1;
  logic so, so_oe, wel_set, wel_clr, sr_wr, wr_chk, asleep, grant;
  logic [7:0] sr_data, wr_data, sr_rd = 8'hA6;
  logic [13:0] wr_addr;
  int lim = 16384;
  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_set = 0, n_clr = 0, n_srw = 0, n_wr = 0;
  logic [7:0] last_sr;
  logic [13:0] wlog [256];
  logic [7:0] shadow [1024];
  logic m3 = 1'b0;
  logic [7:0] rx;

  always #2 clk = ~clk;

  assign grant = (int'(wr_addr) < lim);

  spi_mem_target dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si), .holdn_i(holdn),
    .so_o(so), .so_oe_o(so_oe), .wel_set_o(wel_set), .wel_clr_o(wel_clr),
    .sr_wr_o(sr_wr), .sr_data_o(sr_data), .sr_rd_i(sr_rd), .wr_chk_o(wr_chk),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_grant_i(grant), .asleep_o(asleep)
  );

  always @(negedge clk) begin
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
    if (sr_wr) begin n_srw++; last_sr = sr_data; end
    if (wr_chk) begin wlog[n_wr % 256] = wr_addr; n_wr++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 53) ^ (a >> 3));
  endfunction

  task automatic w8(input int n); repeat (n) @(negedge clk); endtask

  task automatic cs_on();
    sck = m3; w8(H); csn = 1'b0; w8(H);
  endtask

  task automatic cs_off();
    if (!m3) begin sck = 1'b0; w8(H); end
    csn = 1'b1; w8(H + 4);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = tx[i]; w8(H); r[i] = so; sck = 1'b1; w8(H);
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] r);
    bits(tx, 8, r);
  endtask

  task automatic wr_burst(input logic [15:0] a, input int n, input int extra, input int seed);
    logic [7:0] r;
    int ad;
    cs_on(); xb(8'h02, r); xb(a[15:8], r); xb(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      ad = (int'(a[13:0]) + k) % 16384;
      xb(pat(seed + k), r);
      if (ad < lim) shadow[ad % 1024] = pat(seed + k);
    end
    if (extra > 0) bits(pat(seed + n), extra, r);
    cs_off();
  endtask

  task automatic rd_burst(input string req, input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_on(); xb(8'h03, r); xb(a[15:8], r); xb(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      xb(8'h00, r);
      chk(req, r, shadow[((int'(a[13:0]) + k) % 16384) % 1024]);
    end
    cs_off();
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    cs_on(); xb(op, r); cs_off();
  endtask

  initial begin
    int b;
    logic [7:0] r;
    w8(5); rst_n = 1'b1; w8(5);
    // R11 R13 reset state
    chk("R13", so_oe, 0);
    chk("R12", asleep, 0);
    chk("R11", n_set + n_clr + n_srw + n_wr, 0);

    // R1 R5 R6: sweep in both polarities, read back in the other one
    for (int m = 0; m < 2; m++) begin
      m3 = m[0];
      b = n_wr;
      wr_burst(16'(16'h0100 + m * 16'h40), 24, 0, m * 100);
      chk("R6", n_wr - b, 24);
      chk("R6", wlog[(n_wr - 1) % 256], 14'(16'h0100 + m * 16'h40 + 23));
      m3 = ~m3;
      rd_burst("R1", 16'(16'h0100 + m * 16'h40), 24);
    end
    m3 = 1'b0;

    // R3 status stream in both polarities
    for (int m = 0; m < 2; m++) begin
      m3 = m[0];
      cs_on(); xb(8'h05, r);
      xb(8'h00, r); chk("R3", r, 8'hA6);
      sr_rd = 8'h3C;
      xb(8'h00, r); chk("R3", r, 8'h3C);
      cs_off(); sr_rd = 8'hA6;
    end
    m3 = 1'b0;

    // R2 R9
    cmd(8'h06); chk("R2", n_set, 1); chk("R2", n_clr, 0);
    cmd(8'h04); chk("R2", n_clr, 1); chk("R2", n_set, 1);
    cs_on(); xb(8'h06, r); xb(8'h04, r); cs_off();
    chk("R9", n_set, 2); chk("R9", n_clr, 1);

    // R4 R8
    cs_on(); xb(8'h01, r); xb(8'h8C, r); cs_off();
    chk("R4", n_srw, 1); chk("R4", last_sr, 8'h8C);
    cs_on(); xb(8'h01, r); xb(8'h55, r); bits(8'hF0, 4, r); cs_off();
    chk("R8", n_srw, 1);
    cs_on(); bits(8'h06, 5, r); cs_off();
    chk("R8", n_set, 2);
    wr_burst(16'h0200, 3, 0, 7);
    b = n_wr;
    wr_burst(16'h0200, 2, 3, 40);
    chk("R8", n_wr - b, 2);
    rd_burst("R8", 16'h0200, 3);

    // R6 grant boundary
    wr_burst(16'h02FE, 4, 0, 11);
    lim = 16'h0300;
    wr_burst(16'h02FE, 4, 0, 70);
    lim = 16384;
    rd_burst("R6", 16'h02FE, 4);

    // R7 upper bits ignored and wrap
    b = n_wr;
    wr_burst(16'hFFFF, 2, 0, 90);
    chk("R7", wlog[b % 256], 14'h3FFF);
    chk("R7", wlog[(b + 1) % 256], 14'h0000);
    rd_burst("R7", 16'hC000, 1);
    rd_burst("R7", 16'h3FFF, 2);

    // R10 pause during a write byte
    cs_on(); xb(8'h02, r); xb(8'h00, r); xb(8'h50, r);
    bits(8'hC9, 4, r);
    holdn = 1'b0; w8(H);
    chk("R10", so_oe, 0);
    sck = 1'b0; w8(H); sck = 1'b1; w8(H); csn = 1'b1; w8(H);
    sck = 1'b0; w8(H); csn = 1'b0; sck = 1'b1; w8(H);
    holdn = 1'b1; w8(H);
    chk("R13", so_oe, 0);
    for (int i = 3; i >= 0; i--) begin
      sck = 1'b0; si = r[i] | 1'b0; si = (8'hC9 >> i) & 8'h1; w8(H); sck = 1'b1; w8(H);
    end
    cs_off();
    shadow[16'h50] = 8'hC9;
    rd_burst("R10", 16'h0050, 1);

    // R10 R13 pause during a read byte
    cs_on(); xb(8'h03, r); xb(8'h00, r); xb(8'h50, r);
    bits(8'h00, 3, r);
    chk("R13", so_oe, 1);
    holdn = 1'b0; w8(H);
    chk("R10", so_oe, 0);
    sck = 1'b0; w8(H); sck = 1'b1; w8(H);
    holdn = 1'b1; w8(H);
    for (int i = 4; i >= 0; i--) begin
      sck = 1'b0; w8(H); r[i] = so; sck = 1'b1; w8(H);
    end
    cs_off();
    chk("R10", r, 8'hC9);

    // R11 activity while deselected
    b = n_wr;
    for (int i = 0; i < 32; i++) begin
      sck = ~sck; si = i[1]; w8(H);
      if (so_oe) chk("R11", so_oe, 0);
    end
    sck = 1'b0; w8(H);
    chk("R11", n_wr - b, 0);
    chk("R11", n_set, 2);

    // R12 sleep
    cmd(8'hB9);
    chk("R12", asleep, 1);
    cmd(8'h06);
    chk("R12", n_set, 2);
    b = n_wr;
    cs_on(); xb(8'h02, r); xb(8'h00, r); xb(8'h60, r); xb(8'h77, r); cs_off();
    chk("R12", n_wr - b, 0);
    cs_on(); xb(8'h05, r); bits(8'h00, 4, r);
    chk("R12", so_oe, 0);
    cs_off();
    cs_on(); xb(8'hAB, r);
    chk("R12", asleep, 1);
    cs_off();
    chk("R12", asleep, 0);
    cmd(8'h06);
    chk("R12", n_set, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule